// File: doc/BRIEF.md
# Single-Clock Burst FIFO With Quartile Occupancy

This block is a single-clock first-in first-out buffer for 32-bit words. It sits between a memory controller and a video processing stage and absorbs the rate difference between bursty memory transfers and a steady pixel stream. Words are accepted on a write enable and returned in arrival order on a read enable. Read data comes from a register, so it appears one cycle after the read enable.

Besides full and empty flags, the buffer reports how much of its capacity is in use as a coarse two-bit quartile code. A controller watches this code to decide when to request the next memory burst. The code is cheaper to compare than an exact count, and it is stable over a wide range of fill levels. A synchronous clear empties the buffer at any time.

Top module: `qfifo_quartile`

## Requirements
- R1: When `clr` is high at a clock edge, after that edge `empty` is 1, `full` is 0, `level` is 00 and `rd_data` is zero, whatever was stored before.
- R2: When `wr_en` is high and the buffer is not full at a clock edge, `wr_data` is stored, and stored words are returned by later reads in the order they were written.
- R3: When `rd_en` is high and the buffer is not empty at a clock edge, the oldest stored word appears on `rd_data` after that edge. In every other cycle `rd_data` keeps its previous value.
- R4: With N words stored and the default depth of 64, `level` is 00 for N from 0 to 15, 01 for 16 to 31, 10 for 32 to 47, and 11 for 48 to 64.
- R5: `full` is 1 exactly when 64 words are stored, and `empty` is 1 exactly when no word is stored.
- R6: A write while full is dropped: the count stays at 64, and the stored contents and their order are unchanged. With both enables high while full, only the read takes effect.
- R7: A read while empty is dropped: `rd_data` holds its value and the buffer stays empty. With both enables high while empty, only the write takes effect.
- R8: With both enables high while neither full nor empty, the occupancy, `level`, `full` and `empty` stay unchanged, and data order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr | input | 1 | Synchronous clear, active high; empties the buffer |
| wr_en | input | 1 | Store `wr_data` at this edge |
| wr_data | input | 32 | Word to store |
| rd_en | input | 1 | Pop the oldest word at this edge |
| rd_data | output | 32 | Registered output word, valid the cycle after a read |
| full | output | 1 | All entries are occupied |
| empty | output | 1 | No entry is occupied |
| level | output | 2 | Occupancy quartile code |

## Verification
The bench drives the buffer past capacity and past empty. A design that let an overflow write through would advance its write pointer over unread data, and the drained sequence would then show a lost or repeated word. A read on an empty buffer that was not dropped would change `rd_data` or wrap the count, so the flags would become wrong. The bench steps the fill level across the 15/16, 31/32, 47/48 and 63/64 boundaries, where an encoder that took the wrong count bits, or that did not saturate when full, would report the wrong quartile. Long runs of reads and writes in the same cycle at partial fill catch a count that moves when it should hold. A clear issued with data still stored must leave nothing behind.

// File: rtl/qfifo_pkg.sv
package qfifo_pkg;

    localparam int QF_DATA_W     = 32;
    localparam int QF_DEPTH_LOG2 = 6;

    typedef enum logic [1:0] {
        LVL_Q0 = 2'b00,
        LVL_Q1 = 2'b01,
        LVL_Q2 = 2'b10,
        LVL_Q3 = 2'b11
    } level_e;

    typedef struct packed {
        logic push;
        logic pop;
    } xfer_s;

    function automatic xfer_s qualify(input logic wr, input logic rd,
                                      input logic is_full, input logic is_empty);
        xfer_s x;
        x.push = wr && !is_full;
        x.pop  = rd && !is_empty;
        return x;
    endfunction

endpackage

// File: rtl/qfifo_ctrl.sv
module qfifo_ctrl
    import qfifo_pkg::*;
#(
    parameter int AW = QF_DEPTH_LOG2
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          wr_en,
    input  logic          rd_en,
    output xfer_s         xfer,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   count,
    output logic          full,
    output logic          empty
);
    localparam logic [AW:0] DEPTH_CNT = (AW+1)'(1) << AW;

    logic [AW-1:0] wr_q, rd_q;
    logic [AW:0]   cnt_q;

    assign full  = (cnt_q == DEPTH_CNT);
    assign empty = (cnt_q == '0);
    assign xfer  = qualify(wr_en, rd_en, full, empty);

    always_ff @(posedge clk) begin
        if (clr) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (xfer.push) wr_q <= wr_q + 1'b1;
            if (xfer.pop)  rd_q <= rd_q + 1'b1;
            case ({xfer.push, xfer.pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign wr_addr = wr_q;
    assign rd_addr = rd_q;
    assign count   = cnt_q;

endmodule

// File: rtl/qfifo_store.sv
module qfifo_store
    import qfifo_pkg::*;
#(
    parameter int DW = QF_DATA_W,
    parameter int AW = QF_DEPTH_LOG2
) (
    input  logic          clk,
    input  logic          clr,
    input  xfer_s         xfer,
    input  logic [AW-1:0] wr_addr,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] out_q;

    always_ff @(posedge clk) begin
        if (xfer.push && !clr) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (clr)           out_q <= '0;
        else if (xfer.pop) out_q <= mem[rd_addr];
    end

    assign rd_data = out_q;

endmodule

// File: rtl/qfifo_level.sv
module qfifo_level
    import qfifo_pkg::*;
#(
    parameter int AW = QF_DEPTH_LOG2
) (
    input  logic [AW:0] count,
    output level_e      level
);
    generate
        if (AW >= 2) begin : g_wide
            always_comb begin
                if (count[AW]) level = LVL_Q3;
                else           level = level_e'(count[AW-1 -: 2]);
            end
        end else begin : g_narrow
            localparam int DEPTH = 1 << AW;
            always_comb begin
                level = level_e'(2'((int'(count) * 4) / (DEPTH + 1)));
            end
        end
    endgenerate

endmodule

// File: rtl/qfifo_quartile.sv
module qfifo_quartile
    import qfifo_pkg::*;
#(
    parameter int DATA_W     = QF_DATA_W,
    parameter int DEPTH_LOG2 = QF_DEPTH_LOG2
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty,
    output logic [1:0]        level
);
    xfer_s                 xfer;
    logic [DEPTH_LOG2-1:0] wr_addr, rd_addr;
    logic [DEPTH_LOG2:0]   count;
    level_e                lvl;

    qfifo_ctrl #(.AW(DEPTH_LOG2)) u_ctrl (
        .clk     (clk),
        .clr     (clr),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .xfer    (xfer),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .count   (count),
        .full    (full),
        .empty   (empty)
    );

    qfifo_store #(.DW(DATA_W), .AW(DEPTH_LOG2)) u_store (
        .clk     (clk),
        .clr     (clr),
        .xfer    (xfer),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    qfifo_level #(.AW(DEPTH_LOG2)) u_level (
        .count (count),
        .level (lvl)
    );

    assign level = lvl;

endmodule

// File: rtl/qfifo_quartile_chk.sv
module qfifo_quartile_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              clr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              full,
    input logic              empty,
    input logic [1:0]        level
);
    AST_CLEAR_EMPTIES: assert property (@(posedge clk)
        clr |=> (empty && !full && level == 2'b00 && rd_data == '0)); // R1

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (clr)
        !(rd_en && !empty) |=> $stable(rd_data)); // R3

    AST_FULL_LEVEL: assert property (@(posedge clk) disable iff (clr)
        full |-> (level == 2'b11 && !empty)); // R4

    AST_EMPTY_LEVEL: assert property (@(posedge clk) disable iff (clr)
        empty |-> level == 2'b00); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (clr)
        (full && wr_en && !rd_en) |=> full); // R6

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (clr)
        (empty && rd_en && !wr_en) |=> (empty && $stable(rd_data))); // R7

    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (clr)
        (wr_en && rd_en && !full && !empty) |=> ($stable(level) && !full && !empty)); // R8

endmodule

bind qfifo_quartile qfifo_quartile_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .clr     (clr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .full    (full),
    .empty   (empty),
    .level   (level)
);

// File: tb/tb_qfifo_quartile.sv
module tb_qfifo_quartile;
    localparam int DW    = 32;
    localparam int DEPTH = 64;

    logic          clk = 1'b0;
    logic          clr = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          full, empty;
    logic [1:0]    level;

    qfifo_quartile dut (
        .clk(clk), .clr(clr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .full(full), .empty(empty), .level(level)
    );

    always #5 clk = ~clk;

    int            n_vec = 0;
    int            n_bad = 0;
    logic [DW-1:0] exp_q[$];
    int            mcount = 0;
    logic          pend_pop = 1'b0;
    logic          pend_clr = 1'b0;
    logic [DW-1:0] last_rd = '0;
    string         tag = "R1";
    bit            finished = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and updates the reference count.
    task automatic step(input logic c, input logic w, input logic r, input logic [DW-1:0] d);
        @(negedge clk);
        clr = c; wr_en = w; rd_en = r; wr_data = d;
        pend_clr = c;
        pend_pop = 1'b0;
        if (c) begin
            mcount = 0;
        end else begin
            logic do_w, do_r;
            do_w = w && (mcount < DEPTH);
            do_r = r && (mcount > 0);
            pend_pop = do_r;
            if (do_w) exp_q.push_back(d);
            mcount = mcount + int'(do_w) - int'(do_r);
        end
    endtask

    // Monitor: compares outputs shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (pend_clr) begin
                exp_q.delete();
                last_rd = '0;
            end else if (pend_pop) begin
                last_rd = exp_q.pop_front();
            end
            check(tag, "rd_data (R2/R3)", rd_data, last_rd);
            check(tag, "full (R5)", DW'(full), DW'(mcount == DEPTH));
            check(tag, "empty (R5)", DW'(empty), DW'(mcount == 0));
            check(tag, "level (R4)", DW'(level),
                  DW'((mcount == DEPTH) ? 3 : mcount / 16));
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        tag = "R1";
        step(1, 0, 0, '0);
        step(1, 0, 0, '0);
        step(0, 0, 0, '0);
        // R2 R4 R5: fill across every quartile boundary
        tag = "R2";
        for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 32'hA000_0000 + i);
        // R6: writes while full are dropped; both enables while full reads only
        tag = "R6";
        for (int i = 0; i < 5; i++) step(0, 1, 0, 32'hDEAD_0000 + i);
        step(0, 1, 1, 32'hBEEF_0001);
        step(0, 1, 0, 32'hA000_1000);
        // R3: drain fully, data in order, hold when idle
        tag = "R3";
        for (int i = 0; i < DEPTH + 2; i++) step(0, 0, (i % 3) != 2, '0);
        while (mcount > 0) step(0, 0, 1, '0);
        // R7: reads while empty are dropped; both while empty writes only
        tag = "R7";
        for (int i = 0; i < 4; i++) step(0, 0, 1, '0);
        step(0, 1, 1, 32'h7777_0001);
        step(0, 0, 1, '0);
        // R8: simultaneous traffic at partial fill
        tag = "R8";
        for (int i = 0; i < 20; i++) step(0, 1, 0, 32'hC000_0000 + i);
        for (int i = 0; i < 30; i++) step(0, 1, 1, 32'hC100_0000 + i);
        for (int i = 0; i < 16; i++) step(0, 1, 0, 32'hC200_0000 + i);
        for (int i = 0; i < 10; i++) step(0, 1, 1, 32'hC300_0000 + i);
        // R1: clear with data stored
        tag = "R1";
        step(1, 0, 0, '0);
        step(0, 0, 1, '0);
        step(0, 1, 0, 32'h5555_AAAA);
        step(0, 0, 1, '0);
        step(0, 0, 0, '0);
        @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule